// File: doc/BRIEF.md
# Bus-Write to Dual-DAC Transmit Bridge

This block joins the asynchronous external memory bus of a host processor to a dual-channel parallel DAC. The host's DMA engine is the bus master. For each transfer it pulls an active-low write strobe low and places a 32-bit word on the data bus. The bridge runs a four-state handshake. It captures the word into a holding register, raises a one-cycle ready to end the transfer, and then waits for the strobe to go high before it will accept another word.

The converter runs at an exact integer fraction of the bus clock, so the bridge makes its sample enable by dividing the bus clock. No FIFO is needed. Each bus word carries one in-phase sample in its lower half and one quadrature sample in its upper half. On a sample enable, a pending word moves from the holding register into the DAC output register, and each half is cut down to its most significant DAC bits. The host normally writes a little faster than the sample rate. A write that arrives while a word is still pending is therefore stalled by withholding ready. If a sample enable finds nothing pending, the outputs keep their old values and a sticky underrun flag is set. This flag is armed only after the first word has reached the DAC.

Top module: `async_dac_tx_bridge`

## Requirements
- R1: When the write strobe is low and no word is pending, ready goes high exactly two clock cycles after the first rising edge that samples the strobe low. The word on the data bus at the second of those edges is the one captured.
- R2: Ready is high for exactly one cycle per accepted word. A strobe held low after ready produces no further ready and no further capture until the strobe has been sampled high.
- R3: A write that arrives while a captured word is still pending gets no ready until that pending word has moved to the DAC output register.
- R4: The sample enable repeats every RATIO bus clock cycles. The `dac_update` output pulses for one cycle at that spacing, in the cycle in which the new output values appear.
- R5: `dac_i` is bits [15 : 16-DAC_W] of the word and `dac_q` is bits [31 : 32-DAC_W]. The 16-DAC_W low bits of each half are dropped.
- R6: Every accepted word is presented on the DAC outputs exactly once, in the order in which the words were accepted, at the first sample enable after its capture.
- R7: At a sample enable with no pending word, `dac_i` and `dac_q` keep their previous values and `underrun` is set. Once set, `underrun` stays high until reset.
- R8: Sample enables that come before the first word has been delivered to the DAC do not set `underrun`.
- R9: While reset is low, ready, both DAC outputs, `dac_update` and `underrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the converter rate is clk / RATIO |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_n | input | 1 | Host write strobe, active low, synchronous to clk |
| bus_wdata | input | BUS_W | Host write data: Q in the upper half, I in the lower half |
| bus_ready | output | 1 | One-cycle acknowledge that ends the host write |
| dac_i | output | DAC_W | In-phase DAC sample |
| dac_q | output | DAC_W | Quadrature DAC sample |
| dac_update | output | 1 | One-cycle pulse at each converter sample instant |
| underrun | output | 1 | Sticky flag: a sample instant found no fresh word |

## Verification
The bench builds the bridge with DAC_W = 12 and RATIO = 6. The narrow DAC width means the dropped low bits of both halves are actually observable. The short sample period puts both stall cases within a few hundred cycles. With a back-to-back stream, each new write has to wait for the previous word to be consumed. Once the writes stop, or the strobe is held long after ready, the sample enables run dry and the outputs must hold while the underrun flag is set. A quiet period right after reset shows that the flag stays disarmed until the first word has been delivered.

// File: rtl/txb_pkg.sv
// Shared types for the bus-write to DAC transmit bridge.
// Assumes nothing beyond IEEE 1800-2017 packages.
package txb_pkg;

    // Write handshake states, in the order the machine walks them.
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_LATCH   = 2'd1,
        HS_ACK     = 2'd2,
        HS_RELEASE = 2'd3
    } hs_state_t;

endpackage

// File: rtl/txb_rate_gen.sv
// Converter sample-enable generator.
// Divides the bus clock by RATIO and pulses en_o for one cycle per period.
// Assumes the converter clock is an exact integer fraction of the bus clock.
module txb_rate_gen #(
    parameter int RATIO = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic en_o
);

    generate
        if (RATIO <= 1) begin : g_every
            // Converter runs at the bus rate: enable every cycle.
            assign en_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

            logic [CW-1:0] cnt_q;

            // Free-running modulo-RATIO counter.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end

            assign en_o = (cnt_q == LAST);

            // R4: an enable is never followed directly by another one.
            p_en_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                en_o |=> !en_o);

            // R4: the period restarts from zero after each enable.
            p_en_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
                en_o |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/txb_wr_handshake.sv
// Host write handshake and holding register.
// Walks IDLE -> LATCH -> ACK -> RELEASE. It captures the bus word in LATCH,
// raises ready in ACK, and waits in RELEASE until the strobe goes high.
// A new write is not entered while a captured word is still pending.
// Assumes the write strobe and data are synchronous to clk.
module txb_wr_handshake
    import txb_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_n_i,
    input  logic [BUS_W-1:0] data_i,
    input  logic             consume_i,
    output logic             rdy_o,
    output logic [BUS_W-1:0] hold_o,
    output logic             pend_o
);

    hs_state_t        state_q, state_d;
    logic [BUS_W-1:0] hold_q;
    logic             pend_q;

    // Next-state logic of the four-state write handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:    if (!wr_n_i && !pend_q) state_d = HS_LATCH;
            HS_LATCH:   state_d = HS_ACK;
            HS_ACK:     state_d = HS_RELEASE;
            HS_RELEASE: if (wr_n_i) state_d = HS_IDLE;
            default:    state_d = HS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Holding register: takes the bus word while in LATCH.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (state_q == HS_LATCH) hold_q <= data_i;
    end

    // Pending flag: set by a capture, cleared when the output stage takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend_q <= 1'b0;
        else if (state_q == HS_LATCH) pend_q <= 1'b1;
        else if (consume_i)           pend_q <= 1'b0;
    end

    assign rdy_o  = (state_q == HS_ACK);
    assign hold_o = hold_q;
    assign pend_o = pend_q;

    // R2: ready lasts exactly one cycle.
    p_rdy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |=> !rdy_o);

    // R2: after ready the machine waits for a high strobe before a new capture.
    p_wait_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RELEASE && !wr_n_i) |=> (state_q == HS_RELEASE));

    // R1: a ready is always preceded by a strobe sampled low two cycles earlier.
    p_rdy_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(!wr_n_i, 2));

    // R3: no capture starts while a word is still pending.
    p_withhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_IDLE && pend_q && !consume_i) |=> (state_q != HS_LATCH));

    // R6: the output stage only takes a word that is pending.
    p_consume_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |-> pend_q);

endmodule

// File: rtl/txb_dac_stage.sv
// DAC output register with I/Q unpacking and underrun detection.
// On each sample enable it loads the pending word (I from the low half,
// Q from the high half, each cut to its DAC_W most significant bits), or
// holds the outputs and flags an underrun once the stream has started.
// Assumes DAC_W <= BUS_W / 2.
module txb_dac_stage #(
    parameter int BUS_W = 32,
    parameter int DAC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             pend_i,
    input  logic [BUS_W-1:0] hold_i,
    output logic             consume_o,
    output logic [DAC_W-1:0] dac_i_o,
    output logic [DAC_W-1:0] dac_q_o,
    output logic             tick_o,
    output logic             underrun_o
);

    localparam int FIELD_W = BUS_W / 2;
    localparam int DROP_W  = FIELD_W - DAC_W;

    logic [DAC_W-1:0] i_field, q_field;
    logic [DAC_W-1:0] dac_i_q, dac_q_q;
    logic             tick_q, underrun_q, armed_q;

    // Pick the most significant DAC_W bits of each half of the word.
    assign i_field = hold_i[FIELD_W-1 -: DAC_W];
    assign q_field = hold_i[BUS_W-1   -: DAC_W];

    generate
        if (DROP_W > 0) begin : g_drop
            // The dropped low bits of each half are deliberately left unused.
            logic drop_unused;
            assign drop_unused = ^{hold_i[DROP_W-1:0], hold_i[FIELD_W +: DROP_W]};
        end
    endgenerate

    assign consume_o = en_i & pend_i;

    // Output register: load on a fresh word, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_i_q <= '0;
            dac_q_q <= '0;
        end else if (consume_o) begin
            dac_i_q <= i_field;
            dac_q_q <= q_field;
        end
    end

    // Update pulse aligned with the cycle the outputs change.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= en_i;
    end

    // Arming: the first delivered word enables underrun detection.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (consume_o) armed_q <= 1'b1;
    end

    // Sticky underrun: a sample instant with nothing pending after arming.
    always_ff @(posedge clk) begin
        if (!rst_n)                          underrun_o_set_clear: underrun_q <= 1'b0;
        else if (en_i && !pend_i && armed_q) underrun_q <= 1'b1;
    end

    assign dac_i_o    = dac_i_q;
    assign dac_q_o    = dac_q_q;
    assign tick_o     = tick_q;
    assign underrun_o = underrun_q;

    // R7: a sample instant without a fresh word leaves both outputs unchanged.
    p_hold_on_starve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !pend_i) |=> ($stable(dac_i_q) && $stable(dac_q_q)));

    // R7: the underrun flag never clears outside reset.
    p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_q |=> underrun_q);

    // R8: no underrun before the first word has been delivered.
    p_no_early_underrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !underrun_q);

    // R4: outputs only change in the cycle the update pulse is shown.
    p_change_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_q |-> ($stable(dac_i_q) && $stable(dac_q_q)));

endmodule

// File: rtl/async_dac_tx_bridge.sv
// Top of the bus-write to dual-DAC transmit bridge.
// Connects the write handshake, the converter-rate divider and the DAC
// output stage. One bus word carries one I/Q pair; no FIFO is used.
// Assumes bus strobe/data are synchronous to clk and that the converter
// runs at exactly clk / RATIO.
module async_dac_tx_bridge #(
    parameter int BUS_W = 32,
    parameter int DAC_W = 14,
    parameter int RATIO = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_n,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic             bus_ready,
    output logic [DAC_W-1:0] dac_i,
    output logic [DAC_W-1:0] dac_q,
    output logic             dac_update,
    output logic             underrun
);

    logic             sample_en;
    logic             consume;
    logic             pending;
    logic [BUS_W-1:0] hold_word;

    txb_rate_gen #(
        .RATIO (RATIO)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en_o  (sample_en)
    );

    txb_wr_handshake #(
        .BUS_W (BUS_W)
    ) u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_n_i    (bus_wr_n),
        .data_i    (bus_wdata),
        .consume_i (consume),
        .rdy_o     (bus_ready),
        .hold_o    (hold_word),
        .pend_o    (pending)
    );

    txb_dac_stage #(
        .BUS_W (BUS_W),
        .DAC_W (DAC_W)
    ) u_dac (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (sample_en),
        .pend_i     (pending),
        .hold_i     (hold_word),
        .consume_o  (consume),
        .dac_i_o    (dac_i),
        .dac_q_o    (dac_q),
        .tick_o     (dac_update),
        .underrun_o (underrun)
    );

    // R9: reset clears ready and the DAC-side outputs (checked one cycle on).
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (!bus_ready && !dac_update && !underrun && dac_i == '0 && dac_q == '0));

endmodule

// File: tb/async_dac_tx_bridge_tb_top.sv
// Scoreboard bench: the write driver queues each accepted word, and the
// monitor pops it at the next update pulse and compares the DAC outputs.
module async_dac_tx_bridge_tb_top;

    localparam int BW = 32;
    localparam int DW = 12;
    localparam int RT = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic [BW-1:0] wdata = '0;
    logic          ready;
    logic [DW-1:0] dac_i, dac_q;
    logic          upd, urun;

    int n_cmp = 0;
    int n_bad = 0;
    logic [BW-1:0] exp_q[$];
    bit            mon_on = 1'b0;

    always #10 clk = ~clk;

    async_dac_tx_bridge #(.BUS_W(BW), .DAC_W(DW), .RATIO(RT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_n(wr_n), .bus_wdata(wdata),
        .bus_ready(ready), .dac_i(dac_i), .dac_q(dac_q),
        .dac_update(upd), .underrun(urun)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one host write; optionally checks idle latency, optionally holds the strobe.
    task automatic write_word(input logic [BW-1:0] w, input bit idle_case, input int hold_extra);
        int waited = 0;
        @(negedge clk);
        wr_n  = 1'b0;
        wdata = w;
        do begin
            @(negedge clk);
            waited++;
        end while (!ready && waited < 400);
        if (idle_case) check(waited == 2, "R1", "ready latency", waited, 2);
        check(exp_q.size() == 0, "R3", "ready while prior word pending", exp_q.size(), 0);
        exp_q.push_back(w);
        for (int k = 0; k < hold_extra; k++) begin
            wdata = ~w;
            @(negedge clk);
            check(!ready, "R2", "ready while strobe held", ready, 0);
        end
        wr_n  = 1'b1;
        wdata = ~w;
        @(negedge clk);
        check(!ready, "R2", "ready after release", ready, 0);
    endtask

    // Monitor: compares each update against the scoreboard model.
    initial begin
        int cyc = 0;
        int last_tick = -1;
        bit started = 1'b0;
        bit model_ur = 1'b0;
        logic [DW-1:0] ei = '0, eq = '0;
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (mon_on && upd) begin
                if (last_tick >= 0)
                    check(cyc - last_tick == RT, "R4", "update spacing", cyc - last_tick, RT);
                last_tick = cyc;
                if (exp_q.size() > 0) begin
                    logic [BW-1:0] w;
                    w  = exp_q.pop_front();
                    ei = DW'(w[15:0] >> (16 - DW));
                    eq = DW'(w[31:16] >> (16 - DW));
                    started = 1'b1;
                    check(dac_i == ei, "R5", "dac_i of new word", dac_i, ei);
                    check(dac_q == eq, "R6", "dac_q of new word", dac_q, eq);
                end else begin
                    if (started) model_ur = 1'b1;
                    check(dac_i == ei && dac_q == eq, "R7", "held outputs",
                          {dac_q, dac_i}, {eq, ei});
                end
                check(urun == model_ur, started ? "R7" : "R8", "underrun flag", urun, model_ur);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state.
        check(!ready && !upd && !urun, "R9", "control outputs in reset", {ready, upd, urun}, 0);
        check(dac_i == '0 && dac_q == '0, "R9", "dac outputs in reset", {dac_q, dac_i}, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R8: quiet period before any word; underrun must stay low.
        repeat (5 * RT) @(negedge clk);
        check(!urun, "R8", "underrun before first word", urun, 0);

        // R1, R5: first word from idle, then boundary patterns streamed back-to-back (R3, R6).
        write_word(32'h8001_7FFF, 1'b1, 0);
        write_word(32'hFFFF_0000, 1'b0, 0);
        write_word(32'h0000_FFFF, 1'b0, 0);
        write_word(32'h000F_FFF0, 1'b0, 0);
        for (int k = 0; k < 16; k++)
            write_word({16'hA5C3 ^ 16'(k * 16'h1357), 16'h0F0F + 16'(k * 16'h0421)}, 1'b0, 0);

        // R7: let the stream run dry; outputs hold and underrun latches.
        repeat (4 * RT) @(negedge clk);
        check(urun, "R7", "underrun after stream stops", urun, 1);

        // R2: strobe held long after ready, from idle (R1 latency again).
        write_word(32'h1234_ABCD, 1'b1, 4);
        repeat (3 * RT) @(negedge clk);
        check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        check(urun, "R7", "underrun stays set", urun, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule